// File: doc/BRIEF.md
# Integer ADD Instruction Byte Decoder

This block takes a stream of instruction bytes, one byte in each cycle where `byte_vld` is high, and decodes the integer ADD family of a 64-bit machine. It accepts any run of lock and operand-size prefixes, then an optional REX byte, then the opcode, a ModRM byte where the opcode needs one, and an immediate of one, two or four bytes. At the end it emits one decoded record. The record carries the operand form, the operand size, the register indices, whether the r/m operand is in memory, the raw immediate with a flag that tells the consumer to sign-extend it, a fault flag for an illegal lock, and a flag for byte streams that are not an ADD.

The decoder does not consume SIB or displacement bytes, and it does not compute addresses or execute anything. A memory-form ModRM is followed directly by the immediate, if there is one. The record is registered. It is valid for exactly one cycle, the cycle after the clock edge that takes the last byte. The parser is then ready for the next instruction with no idle cycle between the two.

Top module: `addop_decoder`

## Requirements
- R1: `rec_vld` is low after reset. It is high for one cycle after the edge that takes the last byte of an instruction, and only then. Prefixes are F0 (lock), 66 (16-bit size) and 40..4F (REX, with W, R, X and B in bits 3..0). Any other byte in prefix position is the opcode.
- R2: `rec_form` is 0 for RM (opcodes 02/03), 1 for MR (00/01), 2 for MI (80/81/83) and 3 for the accumulator form (04/05). The accumulator form reports reg=0, rm=0 and a register operand.
- R3: `rec_size` is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Even opcodes are 8-bit. For odd opcodes, REX.W gives 64 bits. Otherwise a 66 prefix gives 16 bits, and with neither the size is 32 bits.
- R4: The immediate is 1 byte for 04, 80 and 83, and 2 bytes (16-bit size) or 4 bytes (otherwise) for 05 and 81. It arrives least significant byte first. `rec_imm` holds it zero-extended, and it is 0 when there is no immediate.
- R5: `rec_imm_sx` is 1 for opcode 83 at 16, 32 or 64 bits, and for 05 or 81 at 64 bits. It is 0 otherwise.
- R6: `rec_reg` = {REX.R, ModRM[5:3]} and `rec_rm` = {REX.B, ModRM[2:0]}. `rec_rm_mem` is 1 unless ModRM[7:6] = 3.
- R7: `rec_hibyte` is 1 exactly when the size is 8 bits and no REX byte was present. In that case register codes 4..7 name the high bytes of registers 0..3.
- R8: `rec_lock_ud` is 1 when a lock prefix was present and the destination is not memory. The destination is memory only for MR and MI forms with `rec_rm_mem` = 1.
- R9: For an opcode outside {00..05, 80, 81, 83}, the record with `rec_not_add`=1 follows the opcode byte. For 80/81/83 with ModRM[5:3] ≠ 0, it follows the ModRM byte and no immediate is consumed. For such records only `rec_not_add` and `rec_len` are defined.
- R10: A REX byte counts only when it comes right before the opcode. A lock or 66 byte that follows it cancels it.
- R11: `rec_len` counts every byte of the instruction, prefixes included, and saturates at 2^LEN_W-1.
- R12: A cycle with `byte_vld` low changes no state, whatever `byte_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Instruction byte |
| rec_vld | output | 1 | Decoded record valid (one-cycle pulse) |
| rec_form | output | 2 | Operand form: RM, MR, MI, accumulator |
| rec_size | output | 2 | Operand size code |
| rec_reg | output | 4 | Reg-field register index |
| rec_rm | output | 4 | r/m-field register index |
| rec_rm_mem | output | 1 | r/m operand is memory |
| rec_hibyte | output | 1 | Byte codes 4..7 name high-byte registers |
| rec_imm | output | 8*IMM_BYTES | Immediate, zero-extended |
| rec_imm_sx | output | 1 | Immediate must be sign-extended to the operand size |
| rec_lock_ud | output | 1 | Undefined-opcode fault from lock |
| rec_not_add | output | 1 | Byte stream is not an ADD |
| rec_len | output | LEN_W | Instruction byte count, saturating |

## Verification
The bench builds the decoder with IMM_BYTES=4 and LEN_W=3. With a 3-bit length, an eight-byte lock, triple-66 and imm16 instruction runs past the saturation point at 7, and a seven-byte REX.W memory-form instruction lands exactly on it. Four-byte immediates still reach the full 32-bit immediate path, so 16-, 32- and 64-bit operand sizes all meet the sign-extension rule.

// File: rtl/addop_pkg.sv
package addop_pkg;
  typedef enum logic [1:0] {FORM_RM = 2'd0, FORM_MR = 2'd1, FORM_MI = 2'd2, FORM_ACC = 2'd3} form_e;
  typedef enum logic [1:0] {OSZ_8 = 2'd0, OSZ_16 = 2'd1, OSZ_32 = 2'd2, OSZ_64 = 2'd3} osz_e;
  typedef enum logic [1:0] {IMM_NONE = 2'd0, IMM_ONE = 2'd1, IMM_FULL = 2'd2} immk_e;
  typedef enum logic [1:0] {ST_PFX = 2'd0, ST_MODRM = 2'd1, ST_IMM = 2'd2} pst_e;
  localparam logic [7:0] PFX_LOCK = 8'hF0;
  localparam logic [7:0] PFX_OSZ  = 8'h66;
endpackage

// File: rtl/addop_opclass.sv
module addop_opclass
  import addop_pkg::*;
(
  input  logic [7:0] opc,
  output logic       known,
  output form_e      form,
  output logic       byte_op,
  output immk_e      immk,
  output logic       grp,
  output logic       narrow_imm
);
  always_comb begin
    known      = 1'b1;
    form       = FORM_RM;
    immk       = IMM_NONE;
    grp        = 1'b0;
    narrow_imm = 1'b0;
    byte_op    = ~opc[0];
    case (opc)
      8'h00, 8'h01: form = FORM_MR;
      8'h02, 8'h03: form = FORM_RM;
      8'h04: begin form = FORM_ACC; immk = IMM_ONE;  end
      8'h05: begin form = FORM_ACC; immk = IMM_FULL; end
      8'h80: begin form = FORM_MI; immk = IMM_ONE;  grp = 1'b1; end
      8'h81: begin form = FORM_MI; immk = IMM_FULL; grp = 1'b1; end
      8'h83: begin form = FORM_MI; immk = IMM_ONE;  grp = 1'b1; narrow_imm = 1'b1; end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/addop_immcol.sv
module addop_immcol #(
  parameter int IMM_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   take,
  input  logic [7:0]             din,
  output logic [IMM_BYTES*8-1:0] value_now
);
  localparam int IMM_W = IMM_BYTES * 8;
  localparam int PTR_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

  logic [IMM_W-1:0] val_q;
  logic [PTR_W-1:0] ptr_q;

  // each lane takes the arriving byte when the pointer selects it
  for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
    assign value_now[g*8 +: 8] = (take && ptr_q == PTR_W'(g)) ? din : val_q[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val_q <= '0;
      ptr_q <= '0;
    end else if (take) begin
      val_q <= value_now;
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/addop_decoder.sv
module addop_decoder
  import addop_pkg::*;
#(
  parameter int IMM_BYTES = 4,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_vld,
  input  logic [7:0]             byte_in,
  output logic                   rec_vld,
  output logic [1:0]             rec_form,
  output logic [1:0]             rec_size,
  output logic [3:0]             rec_reg,
  output logic [3:0]             rec_rm,
  output logic                   rec_rm_mem,
  output logic                   rec_hibyte,
  output logic [IMM_BYTES*8-1:0] rec_imm,
  output logic                   rec_imm_sx,
  output logic                   rec_lock_ud,
  output logic                   rec_not_add,
  output logic [LEN_W-1:0]       rec_len
);
  localparam int IMM_W = IMM_BYTES * 8;
  localparam int CNT_W = $clog2(IMM_BYTES + 1);

  pst_e             st_q;
  logic             lock_q, osz_q, rex_p_q, rex_w_q, rex_r_q, rex_b_q;
  form_e            form_q;
  osz_e             size_q;
  logic             sx_q, mem_q;
  logic [CNT_W-1:0] imm_left_q;
  logic [3:0]       reg_q, rm_q;
  logic [LEN_W-1:0] len_q, len_nxt;

  logic       oc_known, oc_byte, oc_grp, oc_narrow;
  form_e      oc_form;
  immk_e      oc_immk;
  osz_e       oc_size;
  logic [CNT_W-1:0] oc_imm_n;
  logic       oc_sx, is_rex, is_lock, is_osz;
  logic [3:0] m_reg, m_rm;
  logic       m_mem;
  logic       emit, emit_na, take;
  logic [3:0] e_reg, e_rm;
  logic       e_mem, e_ud;
  logic [IMM_W-1:0] imm_now;

  addop_opclass u_cls (
    .opc(byte_in), .known(oc_known), .form(oc_form), .byte_op(oc_byte),
    .immk(oc_immk), .grp(oc_grp), .narrow_imm(oc_narrow)
  );

  addop_immcol #(.IMM_BYTES(IMM_BYTES)) u_imm (
    .clk(clk), .rst(rst), .clr(emit), .take(take), .din(byte_in), .value_now(imm_now)
  );

  assign is_lock = (byte_in == PFX_LOCK);
  assign is_osz  = (byte_in == PFX_OSZ);
  assign is_rex  = (byte_in[7:4] == 4'h4);
  assign len_nxt = (&len_q) ? len_q : len_q + 1'b1;

  // operand size and immediate shape of the opcode on the bus
  always_comb begin
    if (oc_byte)                    oc_size = OSZ_8;
    else if (rex_p_q && rex_w_q)    oc_size = OSZ_64;
    else if (osz_q)                 oc_size = OSZ_16;
    else                            oc_size = OSZ_32;
    case (oc_immk)
      IMM_ONE:  oc_imm_n = CNT_W'(1);
      IMM_FULL: oc_imm_n = (oc_size == OSZ_16) ? CNT_W'(2) : CNT_W'(IMM_BYTES);
      default:  oc_imm_n = '0;
    endcase
    oc_sx = (oc_narrow && !oc_byte) || (oc_immk == IMM_FULL && oc_size == OSZ_64);
  end

  assign m_reg = {rex_r_q, byte_in[5:3]};
  assign m_rm  = {rex_b_q, byte_in[2:0]};
  assign m_mem = (byte_in[7:6] != 2'b11);
  assign take  = byte_vld && (st_q == ST_IMM);

  always_comb begin
    emit    = 1'b0;
    emit_na = 1'b0;
    case (st_q)
      ST_PFX: if (byte_vld && !is_lock && !is_osz && !is_rex && !oc_known) begin
        emit = 1'b1; emit_na = 1'b1;
      end
      ST_MODRM: if (byte_vld) begin
        if (form_q == FORM_MI && byte_in[5:3] != 3'd0) begin
          emit = 1'b1; emit_na = 1'b1;
        end else if (imm_left_q == '0) begin
          emit = 1'b1;
        end
      end
      ST_IMM: if (byte_vld && imm_left_q == CNT_W'(1)) emit = 1'b1;
      default: ;
    endcase
    e_reg = (st_q == ST_MODRM) ? m_reg : reg_q;
    e_rm  = (st_q == ST_MODRM) ? m_rm  : rm_q;
    e_mem = (st_q == ST_MODRM) ? m_mem : mem_q;
    e_ud  = lock_q && !(e_mem && (form_q == FORM_MR || form_q == FORM_MI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_PFX;
      lock_q <= 1'b0; osz_q <= 1'b0;
      rex_p_q <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
      form_q <= FORM_RM; size_q <= OSZ_8; sx_q <= 1'b0; mem_q <= 1'b0;
      imm_left_q <= '0; reg_q <= '0; rm_q <= '0; len_q <= '0;
      rec_vld <= 1'b0; rec_form <= '0; rec_size <= '0; rec_reg <= '0; rec_rm <= '0;
      rec_rm_mem <= 1'b0; rec_hibyte <= 1'b0; rec_imm <= '0; rec_imm_sx <= 1'b0;
      rec_lock_ud <= 1'b0; rec_not_add <= 1'b0; rec_len <= '0;
    end else begin
      rec_vld <= emit;
      if (emit) begin
        rec_form    <= form_q;
        rec_size    <= size_q;
        rec_reg     <= e_reg;
        rec_rm      <= e_rm;
        rec_rm_mem  <= e_mem;
        rec_hibyte  <= (size_q == OSZ_8) && !rex_p_q;
        rec_imm     <= imm_now;
        rec_imm_sx  <= sx_q;
        rec_lock_ud <= e_ud && !emit_na;
        rec_not_add <= emit_na;
        rec_len     <= len_nxt;
      end
      if (byte_vld) len_q <= len_nxt;
      case (st_q)
        ST_PFX: if (byte_vld) begin
          if (is_lock || is_osz) begin
            lock_q  <= lock_q | is_lock;
            osz_q   <= osz_q | is_osz;
            rex_p_q <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
          end else if (is_rex) begin
            rex_p_q <= 1'b1;
            rex_w_q <= byte_in[3]; rex_r_q <= byte_in[2]; rex_b_q <= byte_in[0];
          end else begin
            form_q     <= oc_form;
            size_q     <= oc_size;
            sx_q       <= oc_sx;
            imm_left_q <= oc_imm_n;
            if (oc_known && oc_form == FORM_ACC) begin
              reg_q <= '0; rm_q <= '0; mem_q <= 1'b0;
              st_q  <= ST_IMM;
            end else if (oc_known) begin
              st_q <= ST_MODRM;
            end
          end
        end
        ST_MODRM: if (byte_vld) begin
          reg_q <= m_reg; rm_q <= m_rm; mem_q <= m_mem;
          st_q  <= ST_IMM;
        end
        ST_IMM: if (byte_vld) imm_left_q <= imm_left_q - 1'b1;
        default: st_q <= ST_PFX;
      endcase
      if (emit) begin
        st_q <= ST_PFX;
        lock_q <= 1'b0; osz_q <= 1'b0;
        rex_p_q <= 1'b0; rex_w_q <= 1'b0; rex_r_q <= 1'b0; rex_b_q <= 1'b0;
        len_q <= '0;
      end
    end
  end
endmodule

// File: rtl/addop_decoder_chk.sv
module addop_decoder_chk #(
  parameter int IMM_BYTES = 4,
  parameter int LEN_W     = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   byte_vld,
  input logic                   rec_vld,
  input logic [1:0]             rec_form,
  input logic [1:0]             rec_size,
  input logic [3:0]             rec_reg,
  input logic [3:0]             rec_rm,
  input logic                   rec_rm_mem,
  input logic                   rec_hibyte,
  input logic [IMM_BYTES*8-1:0] rec_imm,
  input logic                   rec_imm_sx,
  input logic                   rec_lock_ud,
  input logic                   rec_not_add,
  input logic [LEN_W-1:0]       rec_len
);
  localparam int IMM_W = IMM_BYTES * 8;

  // R1
  rec_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld |-> $past(byte_vld));
  // R2
  acc_operands_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !rec_not_add && rec_form == 2'd3) |-> (rec_reg == 4'd0 && rec_rm == 4'd0 && !rec_rm_mem));
  // R4
  byte_imm_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !rec_not_add && rec_size == 2'd0) |-> (rec_imm[IMM_W-1:8] == '0));
  // R5
  sx_not_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !rec_not_add && rec_imm_sx) |-> (rec_size != 2'd0));
  // R7
  hibyte_size_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !rec_not_add && rec_hibyte) |-> (rec_size == 2'd0));
  // R8
  lock_regdest_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && rec_lock_ud) |-> !(rec_rm_mem && (rec_form == 2'd1 || rec_form == 2'd2)));
  // R9
  group_reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !rec_not_add && rec_form == 2'd2) |-> (rec_reg[2:0] == 3'd0));
  // R11
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld |-> (rec_len != '0));
endmodule

bind addop_decoder addop_decoder_chk #(.IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .rec_vld(rec_vld), .rec_form(rec_form),
  .rec_size(rec_size), .rec_reg(rec_reg), .rec_rm(rec_rm), .rec_rm_mem(rec_rm_mem),
  .rec_hibyte(rec_hibyte), .rec_imm(rec_imm), .rec_imm_sx(rec_imm_sx),
  .rec_lock_ud(rec_lock_ud), .rec_not_add(rec_not_add), .rec_len(rec_len)
);

// File: tb/tb_addop_decoder.sv
module tb_addop_decoder;
  localparam int IMM_BYTES = 4;
  localparam int LEN_W     = 3;

  logic clk = 1'b0, rst = 1'b1, byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic rec_vld, rec_rm_mem, rec_hibyte, rec_imm_sx, rec_lock_ud, rec_not_add;
  logic [1:0] rec_form, rec_size;
  logic [3:0] rec_reg, rec_rm;
  logic [31:0] rec_imm;
  logic [LEN_W-1:0] rec_len;

  always #2 clk = ~clk;

  addop_decoder #(.IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in), .rec_vld(rec_vld),
    .rec_form(rec_form), .rec_size(rec_size), .rec_reg(rec_reg), .rec_rm(rec_rm),
    .rec_rm_mem(rec_rm_mem), .rec_hibyte(rec_hibyte), .rec_imm(rec_imm),
    .rec_imm_sx(rec_imm_sx), .rec_lock_ud(rec_lock_ud), .rec_not_add(rec_not_add),
    .rec_len(rec_len)
  );

  typedef struct {
    string tag; logic na; logic [1:0] form, size; logic [3:0] rg, rm;
    logic mem, hib, sx, ud; logic [31:0] imm; logic [2:0] len;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  function automatic exp_t mk(string t, logic na, logic [1:0] f, logic [1:0] sz,
                              logic [3:0] r, logic [3:0] m, logic mem, logic hib,
                              logic sx, logic ud, logic [31:0] imm, logic [2:0] ln);
    exp_t e;
    e.tag = t; e.na = na; e.form = f; e.size = sz; e.rg = r; e.rm = m; e.mem = mem;
    e.hib = hib; e.sx = sx; e.ud = ud; e.imm = imm; e.len = ln;
    return e;
  endfunction

  // driver: first byte in bits [7:0]; gap inserts an idle cycle carrying junk
  task automatic feed(input exp_t e, input logic [63:0] bytes, input int n, input bit gap);
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = bytes[i*8 +: 8];
      if (gap) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'hF0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1'b0; byte_in = 8'h66;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rec_vld && !done) begin
      if (q.size() == 0) begin
        chk("R1", "unexpected record", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R9",  e.tag, {31'd0, rec_not_add}, {31'd0, e.na});
        chk("R11", e.tag, {29'd0, rec_len}, {29'd0, e.len});
        if (!e.na) begin
          chk("R2", e.tag, {30'd0, rec_form}, {30'd0, e.form});
          chk("R3", e.tag, {30'd0, rec_size}, {30'd0, e.size});
          chk("R4", e.tag, rec_imm, e.imm);
          chk("R5", e.tag, {31'd0, rec_imm_sx}, {31'd0, e.sx});
          chk("R6", e.tag, {24'd0, rec_reg, rec_rm}, {24'd0, e.rg, e.rm});
          chk("R6", e.tag, {31'd0, rec_rm_mem}, {31'd0, e.mem});
          chk("R7", e.tag, {31'd0, rec_hibyte}, {31'd0, e.hib});
          chk("R8", e.tag, {31'd0, rec_lock_ud}, {31'd0, e.ud});
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "reset", {31'd0, rec_vld}, 32'd0);
    rst = 1'b0;
    idle(3);
    chk("R1", "idle no record", {31'd0, rec_vld}, 32'd0);
    // form, size, indices
    feed(mk("R6 mr byte", 0, 2'd1, 2'd0, 4'd1, 4'd0, 0, 1, 0, 0, 32'h0, 3'd2), 64'hC800, 2, 0);
    feed(mk("R3 rexw mem", 0, 2'd1, 2'd3, 4'd3, 4'd0, 1, 0, 0, 0, 32'h0, 3'd3), 64'h180148, 3, 0);
    feed(mk("R3 opsize rm", 0, 2'd0, 2'd1, 4'd2, 4'd1, 0, 0, 0, 0, 32'h0, 3'd3), 64'hD10366, 3, 0);
    // accumulator forms
    feed(mk("R2 acc8", 0, 2'd3, 2'd0, 4'd0, 4'd0, 0, 1, 0, 0, 32'h7F, 3'd2), 64'h7F04, 2, 0);
    feed(mk("R4 acc32", 0, 2'd3, 2'd2, 4'd0, 4'd0, 0, 0, 0, 0, 32'h12345678, 3'd5), 64'h1234567805, 5, 0);
    feed(mk("R4 acc16", 0, 2'd3, 2'd1, 4'd0, 4'd0, 0, 0, 0, 0, 32'h1234, 3'd4), 64'h12340566, 4, 0);
    feed(mk("R5 acc64", 0, 2'd3, 2'd3, 4'd0, 4'd0, 0, 0, 1, 0, 32'hFFFFFFFF, 3'd6), 64'hFFFFFFFF0548, 6, 0);
    // immediate group
    feed(mk("R5 op83", 0, 2'd2, 2'd2, 4'd0, 4'd0, 0, 0, 1, 0, 32'h80, 3'd3), 64'h80C083, 3, 0);
    feed(mk("R4 op80 mem", 0, 2'd2, 2'd0, 4'd0, 4'd7, 1, 1, 0, 0, 32'h05, 3'd3), 64'h050780, 3, 0);
    feed(mk("R5 op83 16", 0, 2'd2, 2'd1, 4'd0, 4'd3, 0, 0, 1, 0, 32'hFF, 3'd4), 64'hFFC38366, 4, 0);
    feed(mk("R11 sat exact", 0, 2'd2, 2'd3, 4'd0, 4'd0, 1, 0, 1, 0, 32'hDEADBEEF, 3'd7),
         64'hDEADBEEF408148, 7, 0);
    // REX extension and byte registers
    feed(mk("R6 rexr", 0, 2'd1, 2'd0, 4'd12, 4'd5, 0, 0, 0, 0, 32'h0, 3'd3), 64'hE50044, 3, 0);
    feed(mk("R6 rexb", 0, 2'd0, 2'd0, 4'd0, 4'd12, 0, 0, 0, 0, 32'h0, 3'd3), 64'hC40241, 3, 0);
    feed(mk("R7 bare rex", 0, 2'd1, 2'd0, 4'd4, 4'd0, 0, 0, 0, 0, 32'h0, 3'd3), 64'hE00040, 3, 0);
    // lock rule
    feed(mk("R8 lock mr mem", 0, 2'd1, 2'd2, 4'd1, 4'd0, 1, 0, 0, 0, 32'h0, 3'd3), 64'h0801F0, 3, 0);
    feed(mk("R8 lock rm", 0, 2'd0, 2'd2, 4'd1, 4'd0, 1, 0, 0, 1, 32'h0, 3'd3), 64'h0803F0, 3, 0);
    feed(mk("R8 lock mr reg", 0, 2'd1, 2'd2, 4'd1, 4'd0, 0, 0, 0, 1, 32'h0, 3'd3), 64'hC801F0, 3, 0);
    feed(mk("R8 lock acc", 0, 2'd3, 2'd2, 4'd0, 4'd0, 0, 0, 0, 1, 32'h1, 3'd6), 64'h0000000105F0, 6, 0);
    // not an ADD, then back-to-back decode
    feed(mk("R9 unknown", 1, 2'd0, 2'd0, 4'd0, 4'd0, 0, 0, 0, 0, 32'h0, 3'd1), 64'h0F, 1, 0);
    feed(mk("R9 grp reg1", 1, 2'd0, 2'd0, 4'd0, 4'd0, 0, 0, 0, 0, 32'h0, 3'd2), 64'hC881, 2, 0);
    feed(mk("R9 after notadd", 0, 2'd1, 2'd0, 4'd0, 4'd0, 0, 1, 0, 0, 32'h0, 3'd2), 64'hC000, 2, 0);
    // REX placement
    feed(mk("R10 rex cancel", 0, 2'd1, 2'd1, 4'd0, 4'd0, 0, 0, 0, 0, 32'h0, 3'd4), 64'hC0016648, 4, 0);
    feed(mk("R10 rex last", 0, 2'd1, 2'd3, 4'd0, 4'd0, 0, 0, 0, 0, 32'h0, 3'd4), 64'hC0014866, 4, 0);
    // saturation and idle-cycle hold
    feed(mk("R11 saturate", 0, 2'd2, 2'd1, 4'd0, 4'd0, 1, 0, 0, 0, 32'h1234, 3'd7),
         64'h12340081666666F0, 8, 0);
    feed(mk("R12 gaps", 0, 2'd3, 2'd2, 4'd0, 4'd0, 0, 0, 0, 0, 32'h12345678, 3'd5),
         64'h1234567805, 5, 1);
    idle(4);
    chk("R1", "all records seen", q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule